// File: doc/BRIEF.md
# Programmable Dual-Modulus Cascade Divider

This block divides its input clock by a programmable integer between 8 and 15. It is built from a chain of three identical divide-by-2/3 cells. The first cell counts input clock cycles. Each later cell advances only when the cell before it finishes one of its periods. Without any swallowing, each cell divides by two, so the chain divides by eight. A cell that is allowed to swallow stretches one of its own periods by a single input step of that cell. That step is worth 1, 2 or 4 input clock cycles, depending on how far down the chain the cell sits.

A modulus-enable signal travels back up the chain. The last cell always holds it. Each cell passes it on during the first phase of its own period. As a result, every cell has exactly one window per output period in which it may swallow. The three-bit ratio word is captured at the end of every output period, so a new ratio applies to whole periods only. The output is a pulse one input cycle wide that marks the start of each output period. It is taken from the front of the modulus-enable chain.

All cells run on the input clock and use step enables in place of rippled clocks. This keeps the whole block in one timing domain.

Top module: `mmd_divider`

## Requirements
- R1: While `rst_n` is low, `div_clk` is held high one clock after each sampled reset edge, and every cell restarts at the first phase of its period.
- R2: Every output period, measured from one rising edge of `div_clk` to the next, lasts exactly 8 + `ratio_word` input clock cycles. `ratio_word` is an unsigned binary value.
- R3: Bit 0 of `ratio_word` controls the first cell and adds one input cycle to the period.
- R4: Bit 1 of `ratio_word` controls the second cell and adds two input cycles to the period.
- R5: Bit 2 of `ratio_word` controls the last cell and adds four input cycles to the period.
- R6: `ratio_word` is sampled only on the clock edge that ends an output period. The period that starts at that edge uses the sampled value. A change at any other time has no effect on the period in progress.
- R7: With a constant `ratio_word`, consecutive output periods are identical.
- R8: `div_clk` is high for exactly one input clock cycle per output period once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| ratio_word | input | 3 | Division ratio minus 8 |
| div_clk | output | 1 | One-cycle pulse at the start of each output period |

## Verification
Two things can happen on the same clock edge: the end of an output period, where the ratio word is captured, and a change of the ratio word by the driver. To provoke this, the bench measures a period first. It then places a new word so that it is sampled exactly on the edge that closes the next period. It also places a change one cycle too late, so that it misses that edge. In the first case the very next period must already follow the new word. In the late case that period must keep the old length, and only the period after it may change.

// File: rtl/mmd_pkg.sv
// Package: shared types for the cascaded 2/3 divider.
// Assumes: each cell has at most three phases per period.
package mmd_pkg;

    // Phase of one divide-by-2/3 cell.
    typedef enum logic [1:0] {
        PH_HEAD  = 2'd0,   // first step of the cell period, opens the swallow window
        PH_TAIL  = 2'd1,   // second step, decides whether to stretch
        PH_EXTRA = 2'd2    // stretched step, present only when swallowing
    } cell_phase_t;

    // Number of cells in the default chain.
    localparam int unsigned DEF_STAGES = 3;

endpackage

// File: rtl/mmd_cell.sv
// Module: mmd_cell
// One divide-by-2/3 cell of the cascade. It advances one phase for each
// input step (step_in) and emits step_out as its period ends. When the
// swallow bit is set and the modulus enable from the next cell is active,
// it inserts one extra step. The modulus enable it passes back is active
// only during its head phase, so the previous cell sees one window per
// final period.
// Assumes: step_in is a one-cycle enable in the clk domain.
module mmd_cell
    import mmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_in,
    input  logic mod_in,
    input  logic swallow,
    output logic step_out,
    output logic mod_out
);

    cell_phase_t phase_q;
    cell_phase_t phase_d;
    logic        stretch;

    // Purpose: the stretch decision, valid while in the tail phase.
    assign stretch = swallow && mod_in;

    // Purpose: next-phase and end-of-period step logic.
    always_comb begin
        phase_d  = phase_q;
        step_out = 1'b0;
        if (step_in) begin
            case (phase_q)
                PH_HEAD: phase_d = PH_TAIL;
                PH_TAIL: begin
                    if (stretch) begin
                        phase_d = PH_EXTRA;
                    end else begin
                        phase_d  = PH_HEAD;
                        step_out = 1'b1;
                    end
                end
                PH_EXTRA: begin
                    phase_d  = PH_HEAD;
                    step_out = 1'b1;
                end
                default: phase_d = PH_HEAD;
            endcase
        end
    end

    // Purpose: phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_HEAD;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Purpose: pass the modulus enable back during the head phase only.
    assign mod_out = mod_in && (phase_q == PH_HEAD);

endmodule

// File: rtl/mmd_ratio_latch.sv
// Module: mmd_ratio_latch
// Holds the ratio word for one full output period. It loads on the edge
// that ends a period, and also during reset.
// Assumes: period_end is a one-cycle enable in the clk domain.
module mmd_ratio_latch #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_end,
    input  logic [WIDTH-1:0] word_in,
    output logic [WIDTH-1:0] word_q
);

    // Purpose: capture the ratio word at reset and at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= word_in;
        end else if (period_end) begin
            word_q <= word_in;
        end
    end

endmodule

// File: rtl/mmd_divider.sv
// Module: mmd_divider (top)
// A chain of N_STAGES divide-by-2/3 cells giving a division ratio of
// 2**N_STAGES + ratio_word. Cell k is steered by bit k of the latched word.
// The output pulse is the modulus enable at the front of the chain, which
// is high during the first input cycle of each period.
// Assumes: a single input clock; later cells step on enables, not clocks.
module mmd_divider #(
    parameter int unsigned N_STAGES = mmd_pkg::DEF_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STAGES-1:0] ratio_word,
    output logic                div_clk
);

    logic [N_STAGES:0]   step_chain;
    logic [N_STAGES:0]   mod_chain;
    logic [N_STAGES-1:0] ctl_q;
    logic                period_end;

    // Purpose: the first cell steps on every input cycle; the last is always enabled.
    assign step_chain[0]        = 1'b1;
    assign mod_chain[N_STAGES]  = 1'b1;
    assign period_end           = step_chain[N_STAGES];

    // Purpose: ratio word held for one whole output period.
    mmd_ratio_latch #(.WIDTH(N_STAGES)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_end (period_end),
        .word_in    (ratio_word),
        .word_q     (ctl_q)
    );

    // Purpose: build the cascade of 2/3 cells.
    for (genvar k = 0; k < N_STAGES; k++) begin : g_cell
        mmd_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_in  (step_chain[k]),
            .mod_in   (mod_chain[k+1]),
            .swallow  (ctl_q[k]),
            .step_out (step_chain[k+1]),
            .mod_out  (mod_chain[k])
        );
    end

    // Purpose: output pulse marks the first cycle of each period.
    assign div_clk = mod_chain[0];

endmodule

// File: rtl/mmd_divider_chk.sv
// Module: mmd_divider_chk
// Property checker bound to mmd_divider. It measures periods with its own
// counter and compares them with the word that was sampled at each period start.
module mmd_divider_chk #(
    parameter int unsigned N_STAGES = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_STAGES-1:0] ratio_word,
    input logic                div_clk,
    input logic [N_STAGES-1:0] ctl_q,
    input logic                period_end
);

    localparam int unsigned CW = N_STAGES + 2;

    logic [CW-1:0]       gap_cnt;
    logic [N_STAGES-1:0] exp_word;
    logic                seen_rise;

    // Purpose: count cycles between rising edges of the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt   <= '0;
            exp_word  <= '0;
            seen_rise <= 1'b0;
        end else if ($rose(div_clk)) begin
            gap_cnt   <= CW'(1);
            exp_word  <= $past(ratio_word);
            seen_rise <= 1'b1;
        end else if (gap_cnt != '1) begin
            gap_cnt <= gap_cnt + CW'(1);
        end
    end

    // R1: output held high one cycle after reset is sampled
    assert_reset_high_R1: assert property (@(posedge clk)
        !rst_n |=> div_clk);

    // R2 / R7: each period equals the base ratio plus the word sampled at its start
    assert_period_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rise && $rose(div_clk)) |->
            (gap_cnt == CW'((1 << N_STAGES) + exp_word)));

    // R6: the held word changes only at a period end
    assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(ctl_q));

    // R8: output pulse is one cycle wide
    assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_clk) |=> !div_clk);

    // R8: a period end is followed by the output pulse
    assert_pulse_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> div_clk);

endmodule

bind mmd_divider mmd_divider_chk #(.N_STAGES(N_STAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ratio_word (ratio_word),
    .div_clk    (div_clk),
    .ctl_q      (ctl_q),
    .period_end (period_end)
);

// File: tb/mmd_divider_tb.sv
`timescale 1ns/1ps
// Directed bench for mmd_divider: one task per scenario.
module mmd_divider_tb;

    logic       clk;
    logic       rst_n;
    logic [2:0] ratio_word;
    logic       div_clk;

    int n_checks;
    int n_fail;
    bit finished;

    mmd_divider u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_word (ratio_word),
        .div_clk    (div_clk)
    );

    // 50 MHz input clock
    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait until the negedge where div_clk is first seen high after being low.
    task automatic wait_rise();
        logic prev;
        logic hit;
        prev = div_clk;
        hit  = 1'b0;
        while (!hit) begin
            @(negedge clk);
            hit  = div_clk && !prev;
            prev = div_clk;
        end
    endtask

    // Call at a rise; returns cycles to the next rise.
    task automatic measure(output int n);
        logic prev;
        logic hit;
        n    = 0;
        prev = div_clk;
        hit  = 1'b0;
        while (!hit) begin
            @(negedge clk);
            n++;
            hit  = div_clk && !prev;
            prev = div_clk;
        end
    endtask

    task automatic t_reset();
        rst_n      = 1'b0;
        ratio_word = 3'd0;
        repeat (4) @(negedge clk);
        check(div_clk === 1'b1, "R1 reset output high", int'(div_clk), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(div_clk === 1'b0, "R8 pulse ends after reset", int'(div_clk), 0);
        wait_rise();
    endtask

    // Each word: the change right after a rise leaves the current period alone.
    task automatic t_sweep();
        int n;
        int old_w;
        old_w = int'(ratio_word);
        for (int w = 0; w < 8; w++) begin
            wait_rise();
            ratio_word = 3'(w);
            measure(n);
            check(n == 8 + old_w, "R6 current period keeps old word", n, 8 + old_w);
            measure(n);
            check(n == 8 + w, "R2 period equals 8 plus word", n, 8 + w);
            measure(n);
            check(n == 8 + w, "R7 repeated period", n, 8 + w);
            old_w = w;
        end
    endtask

    task automatic t_single_bits();
        int n;
        int wts[3];
        string tags[3];
        wts[0] = 1; wts[1] = 2; wts[2] = 4;
        tags[0] = "R3 bit0 adds one";
        tags[1] = "R4 bit1 adds two";
        tags[2] = "R5 bit2 adds four";
        for (int b = 0; b < 3; b++) begin
            wait_rise();
            ratio_word = 3'(wts[b]);
            measure(n);
            measure(n);
            check(n == 8 + wts[b], tags[b], n, 8 + wts[b]);
        end
    endtask

    // Word changed so that it is sampled on the very edge closing a period.
    task automatic t_change_at_edge();
        int n;
        wait_rise();
        ratio_word = 3'd3;
        measure(n);
        measure(n);
        check(n == 11, "R2 setup period", n, 11);
        repeat (10) @(negedge clk);
        ratio_word = 3'd5;
        measure(n);
        check(n == 1, "R6 rise follows edge", n, 1);
        measure(n);
        check(n == 13, "R6 word sampled at period end", n, 13);
    endtask

    // Word changed one cycle after the closing edge.
    task automatic t_change_late();
        int n;
        wait_rise();
        ratio_word = 3'd7;
        measure(n);
        measure(n);
        check(n == 15, "R2 maximum ratio", n, 15);
        repeat (15) @(negedge clk);
        ratio_word = 3'd0;
        measure(n);
        check(n == 15, "R6 late change ignored", n, 15);
        measure(n);
        check(n == 8, "R2 minimum ratio", n, 8);
    endtask

    initial begin
        n_checks   = 0;
        n_fail     = 0;
        finished   = 1'b0;
        rst_n      = 1'b0;
        ratio_word = 3'd0;
        t_reset();
        t_sweep();
        t_single_bits();
        t_change_at_edge();
        t_change_late();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule